// File: doc/BRIEF.md
# Channelized I/O Device Hub

This block sits next to a processor core and serves a small set of numbered I/O channels through two request ports: one for reads, one for writes. Each port has its own request line, its own 4-bit channel number and its own acknowledge. Every request is answered one cycle after it is sampled. No request is ever refused.

The read side offers three sources:
- Channel 1 streams words of a stored program image, one word per read.
- Channel 2 returns the value of a free-running cycle counter.
- Channel 3 streams application input words.

The write side offers three targets:
- Channel 1 picks which of the three stored images will be streamed.
- Channel 2 presets the cycle counter.
- Channel 3 captures a debug value, which appears on a dedicated output.

A loader reads address/data pairs from the image stream. A program times a region by reading the counter twice and subtracting.

The images and the input words live in small internal ROMs. Their contents are computed at elaboration.

Top module: `io_hub`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rd_ack`, `wr_ack`, `rd_data` and `dbg_value` are zero. Reset also selects image 0 and rewinds both streams to word 0. It also clears the counter, so a channel-2 read sampled at the first edge with `rst` low returns 0.
- R2: Every read request sampled at an edge is acknowledged by `rd_ack` high for the following cycle only. `rd_data` holds the read value in that cycle and is zero whenever `rd_ack` is low. A request held high is served once per cycle.
- R3: Every write request sampled at an edge is acknowledged by `wr_ack` high for the following cycle only.
- R4: The cycle counter increments by one at every edge at which it is not preset. A channel-2 read returns the count held just before its sampling edge, so two reads n cycles apart differ by n.
- R5: A write to channel 2 loads `wr_data` into the counter; a channel-2 read at the next edge returns exactly that value. The counter wraps from all ones to zero.
- R6: A write to channel 1 with a value of 0, 1 or 2 selects that image and rewinds the image stream to word 0. Any larger value leaves both the selection and the stream position unchanged.
- R7: Successive channel-1 reads return words 0 to 15 of the selected image, then restart at word 0. Word k of image i has bits 33:32 equal to i and bits 31:0 equal to 64*i + k.
- R8: Successive channel-3 reads return input words 0 to 15, then restart at word 0. Word j equals 2^32 + 5*j + 7. Image selection does not move the input stream.
- R9: A write to channel 3 shows `wr_data` on `dbg_value` from the next cycle on. No other write changes `dbg_value`.
- R10: A read of channel 0 or 4 to 15 is acknowledged with zero data and advances no stream. A write to channel 0 or 4 to 15 is acknowledged and changes no state.
- R11: A read and a write presented in the same cycle are both served, each as if alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, sampled each edge |
| rd_chan | input | 4 | Read channel number |
| wr_req | input | 1 | Write request, sampled each edge |
| wr_chan | input | 4 | Write channel number |
| wr_data | input | 34 | Write data |
| rd_ack | output | 1 | Read acknowledge, one cycle |
| rd_data | output | 34 | Read data, valid with `rd_ack` |
| wr_ack | output | 1 | Write acknowledge, one cycle |
| dbg_value | output | 34 | Last value written to the debug channel |

## Verification
A stream pointer that slips or fails to wrap shows up on the very next read of that channel, as a word from the wrong index or the wrong image. The word formulas make every index and image distinguishable. A wrong select, such as an accepted out-of-range value or a missing rewind, is exposed by the first image read after the write. Counter faults show at the next pair of channel-2 reads: a missed increment, a dropped preset or a lost wrap breaks the expected difference immediately.

// File: rtl/io_hub_pkg.sv
package io_hub_pkg;

  // Read-side channel numbers
  localparam int unsigned CH_RD_IMAGE   = 1;
  localparam int unsigned CH_RD_COUNTER = 2;
  localparam int unsigned CH_RD_INPUT   = 3;

  // Write-side channel numbers
  localparam int unsigned CH_WR_SELECT  = 1;
  localparam int unsigned CH_WR_PRESET  = 2;
  localparam int unsigned CH_WR_DEBUG   = 3;

  // Word k of image img: image number in the upper bits, 64*img+k below.
  function automatic logic [63:0] image_word(input int img, input int k);
    return (64'(img) << 32) | 64'(64 * img + k);
  endfunction

  // Word j of the application input stream.
  function automatic logic [63:0] input_word(input int j);
    return 64'h1_0000_0000 + 64'(5 * j + 7);
  endfunction

endpackage

// File: rtl/io_cycle_counter.sv
module io_cycle_counter #(
  parameter int DATA_W = 34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] count_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
    end else if (load) begin
      count_o <= load_val;
    end else begin
      count_o <= count_o + 1'b1;
    end
  end

endmodule

// File: rtl/io_image_stream.sv
module io_image_stream
  import io_hub_pkg::*;
#(
  parameter int DATA_W  = 34,
  parameter int NUM_IMG = 3,
  parameter int DEPTH   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic [DATA_W-1:0] sel_val,
  input  logic              adv,
  output logic [DATA_W-1:0] word_o
);

  localparam int SEL_W = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ROM_N = NUM_IMG * DEPTH;
  localparam int IDX_W = (ROM_N > 1) ? $clog2(ROM_N) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] rom [ROM_N];
  logic [SEL_W-1:0]  sel_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [IDX_W-1:0]  rd_idx;
  logic              sel_ok;

  // Contents computed at elaboration; no writes afterwards, so a ROM is inferred.
  initial begin
    for (int b = 0; b < NUM_IMG; b++) begin
      for (int k = 0; k < DEPTH; k++) begin
        rom[b * DEPTH + k] = DATA_W'(image_word(b, k));
      end
    end
  end

  assign sel_ok = sel_we && (sel_val < DATA_W'(NUM_IMG));
  assign rd_idx = IDX_W'(sel_q) * IDX_W'(DEPTH) + IDX_W'(ptr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      ptr_q <= '0;
    end else if (sel_ok) begin
      sel_q <= sel_val[SEL_W-1:0];
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // Synchronous read of the current position each cycle.
  always_ff @(posedge clk) begin
    word_o <= rom[rd_idx];
  end

endmodule

// File: rtl/io_input_stream.sv
module io_input_stream
  import io_hub_pkg::*;
#(
  parameter int DATA_W = 34,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [DATA_W-1:0] word_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] rom [DEPTH];
  logic [PTR_W-1:0]  ptr_q;

  initial begin
    for (int j = 0; j < DEPTH; j++) begin
      rom[j] = DATA_W'(input_word(j));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    word_o <= rom[ptr_q];
  end

endmodule

// File: rtl/io_hub.sv
module io_hub
  import io_hub_pkg::*;
#(
  parameter int DATA_W    = 34,
  parameter int CHAN_W    = 4,
  parameter int NUM_IMG   = 3,
  parameter int IMG_DEPTH = 16,
  parameter int IN_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [CHAN_W-1:0] rd_chan,
  input  logic              wr_req,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ack,
  output logic [DATA_W-1:0] dbg_value
);

  localparam logic [CHAN_W-1:0] R_IMG = CHAN_W'(CH_RD_IMAGE);
  localparam logic [CHAN_W-1:0] R_CNT = CHAN_W'(CH_RD_COUNTER);
  localparam logic [CHAN_W-1:0] R_INP = CHAN_W'(CH_RD_INPUT);
  localparam logic [CHAN_W-1:0] W_SEL = CHAN_W'(CH_WR_SELECT);
  localparam logic [CHAN_W-1:0] W_PRE = CHAN_W'(CH_WR_PRESET);
  localparam logic [CHAN_W-1:0] W_DBG = CHAN_W'(CH_WR_DEBUG);

  logic              rd_img, rd_cnt, rd_inp;
  logic              wr_sel, wr_pre, wr_dbg;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] img_word;
  logic [DATA_W-1:0] inp_word;
  logic [DATA_W-1:0] cnt_snap_q;
  logic [CHAN_W-1:0] rd_chan_q;
  logic              rd_ack_q;
  logic              wr_ack_q;
  logic [DATA_W-1:0] dbg_q;

  assign rd_img = rd_req && (rd_chan == R_IMG);
  assign rd_cnt = rd_req && (rd_chan == R_CNT);
  assign rd_inp = rd_req && (rd_chan == R_INP);
  assign wr_sel = wr_req && (wr_chan == W_SEL);
  assign wr_pre = wr_req && (wr_chan == W_PRE);
  assign wr_dbg = wr_req && (wr_chan == W_DBG);

  io_cycle_counter #(.DATA_W(DATA_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_pre),
    .load_val (wr_data),
    .count_o  (count)
  );

  io_image_stream #(
    .DATA_W  (DATA_W),
    .NUM_IMG (NUM_IMG),
    .DEPTH   (IMG_DEPTH)
  ) u_image (
    .clk     (clk),
    .rst     (rst),
    .sel_we  (wr_sel),
    .sel_val (wr_data),
    .adv     (rd_img),
    .word_o  (img_word)
  );

  io_input_stream #(
    .DATA_W (DATA_W),
    .DEPTH  (IN_DEPTH)
  ) u_input (
    .clk    (clk),
    .rst    (rst),
    .adv    (rd_inp),
    .word_o (inp_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack_q   <= 1'b0;
      wr_ack_q   <= 1'b0;
      rd_chan_q  <= '0;
      cnt_snap_q <= '0;
      dbg_q      <= '0;
    end else begin
      rd_ack_q <= rd_req;
      wr_ack_q <= wr_req;
      if (rd_req) begin
        rd_chan_q <= rd_chan;
      end
      if (rd_cnt) begin
        cnt_snap_q <= count;
      end
      if (wr_dbg) begin
        dbg_q <= wr_data;
      end
    end
  end

  // All sources are registers captured at the sampling edge.
  always_comb begin
    rd_data = '0;
    if (rd_ack_q) begin
      case (rd_chan_q)
        R_IMG:   rd_data = img_word;
        R_CNT:   rd_data = cnt_snap_q;
        R_INP:   rd_data = inp_word;
        default: rd_data = '0;
      endcase
    end
  end

  assign rd_ack    = rd_ack_q;
  assign wr_ack    = wr_ack_q;
  assign dbg_value = dbg_q;

endmodule

// File: rtl/io_hub_checker.sv
module io_hub_checker #(
  parameter int DATA_W = 34,
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic [CHAN_W-1:0] rd_chan,
  input logic              wr_req,
  input logic [CHAN_W-1:0] wr_chan,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_ack,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_ack,
  input logic [DATA_W-1:0] dbg_value
);

  logic rd_mapped, rd_counter, wr_preset, wr_debug;
  assign rd_mapped  = (rd_chan >= CHAN_W'(1)) && (rd_chan <= CHAN_W'(3));
  assign rd_counter = rd_req && (rd_chan == CHAN_W'(2));
  assign wr_preset  = wr_req && (wr_chan == CHAN_W'(2));
  assign wr_debug   = wr_req && (wr_chan == CHAN_W'(3));

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_ack && !wr_ack && dbg_value == '0));

  // R2
  a_r2_rd_ack_next: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_ack);
  a_r2_rd_ack_single: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_ack);
  a_r2_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |-> rd_data == '0);

  // R3
  a_r3_wr_ack_next: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> wr_ack);
  a_r3_wr_ack_single: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> !wr_ack);

  // R4
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (rd_counter && !wr_preset) ##1 rd_counter |=> rd_data == $past(rd_data) + 1'b1);

  // R5
  a_r5_preset_read: assert property (@(posedge clk) disable iff (rst)
    wr_preset ##1 rd_counter |=> rd_data == $past(wr_data, 2));

  // R9
  a_r9_dbg_capture: assert property (@(posedge clk) disable iff (rst)
    wr_debug |=> dbg_value == $past(wr_data));
  a_r9_dbg_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_debug |=> $stable(dbg_value));

  // R10
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_mapped) |=> (rd_ack && rd_data == '0));

endmodule

bind io_hub io_hub_checker #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_io_hub_checker (
  .clk       (clk),
  .rst       (rst),
  .rd_req    (rd_req),
  .rd_chan   (rd_chan),
  .wr_req    (wr_req),
  .wr_chan   (wr_chan),
  .wr_data   (wr_data),
  .rd_ack    (rd_ack),
  .rd_data   (rd_data),
  .wr_ack    (wr_ack),
  .dbg_value (dbg_value)
);

// File: tb/io_hub_bench.sv
module io_hub_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic [3:0]  rd_chan = '0;
  logic        wr_req = 1'b0;
  logic [3:0]  wr_chan = '0;
  logic [33:0] wr_data = '0;
  logic        rd_ack;
  logic [33:0] rd_data;
  logic        wr_ack;
  logic [33:0] dbg_value;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  io_hub u_io_hub (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_chan   (rd_chan),
    .wr_req    (wr_req),
    .wr_chan   (wr_chan),
    .wr_data   (wr_data),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .wr_ack    (wr_ack),
    .dbg_value (dbg_value)
  );

  function automatic logic [33:0] exp_img(input int i, input int k);
    return {2'(i), 32'(64 * i + k)};
  endfunction

  function automatic logic [33:0] exp_inp(input int j);
    return 34'h1_0000_0000 + 34'(5 * j + 7);
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with data sampled.
  task automatic rd(input logic [3:0] ch, output logic [33:0] d);
    rd_req = 1'b1;
    rd_chan = ch;
    @(negedge clk);
    rd_req = 1'b0;
    check("R2 read ack", 34'(rd_ack), 34'd1);
    d = rd_data;
  endtask

  task automatic wr(input logic [3:0] ch, input logic [33:0] v);
    wr_req = 1'b1;
    wr_chan = ch;
    wr_data = v;
    @(negedge clk);
    wr_req = 1'b0;
    check("R3 write ack", 34'(wr_ack), 34'd1);
  endtask

  task automatic t_reset();
    logic [33:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rd_ack in reset", 34'(rd_ack), 34'd0);
    check("R1 wr_ack in reset", 34'(wr_ack), 34'd0);
    check("R1 rd_data in reset", rd_data, 34'd0);
    check("R1 dbg_value in reset", dbg_value, 34'd0);
    rst = 1'b0;
    rd(4'd2, d);
    check("R1 counter after reset", d, 34'd0);
  endtask

  task automatic t_image_default();
    logic [33:0] d;
    for (int k = 0; k < 3; k++) begin
      rd(4'd1, d);
      check("R7 image0 after reset", d, exp_img(0, k));
    end
  endtask

  task automatic t_input_start();
    logic [33:0] d;
    for (int j = 0; j < 3; j++) begin
      rd(4'd3, d);
      check("R8 input start", d, exp_inp(j));
    end
  endtask

  task automatic t_select();
    logic [33:0] d;
    wr(4'd1, 34'd2);
    rd(4'd1, d);
    check("R6 select image2 rewinds", d, exp_img(2, 0));
    wr(4'd1, 34'd5);
    rd(4'd1, d);
    check("R6 out-of-range select ignored", d, exp_img(2, 1));
    wr(4'd1, 34'd1);
    for (int k = 0; k < 17; k++) begin
      rd(4'd1, d);
      check("R7 image1 stream and wrap", d, exp_img(1, k % 16));
    end
  endtask

  task automatic t_input_wrap();
    logic [33:0] d;
    for (int j = 3; j < 17; j++) begin
      rd(4'd3, d);
      check("R8 input continues and wraps", d, exp_inp(j % 16));
    end
  endtask

  task automatic t_counter();
    logic [33:0] d;
    wr(4'd2, 34'd1000);
    rd(4'd2, d);
    check("R5 preset read back", d, 34'd1000);
    rd(4'd2, d);
    check("R4 next cycle plus one", d, 34'd1001);
    repeat (3) @(negedge clk);
    rd(4'd2, d);
    check("R4 four cycles later", d, 34'd1005);
    wr(4'd2, 34'h3_FFFF_FFFF);
    rd(4'd2, d);
    check("R5 preset all ones", d, 34'h3_FFFF_FFFF);
    rd(4'd2, d);
    check("R5 counter wraps", d, 34'd0);
  endtask

  task automatic t_debug();
    wr(4'd3, 34'h2_DEAD_BEEF);
    check("R9 debug capture", dbg_value, 34'h2_DEAD_BEEF);
    wr(4'd0, 34'd5);
    check("R10 write ch0 no effect on debug", dbg_value, 34'h2_DEAD_BEEF);
    wr(4'd9, 34'd7);
    check("R9 write ch9 leaves debug", dbg_value, 34'h2_DEAD_BEEF);
  endtask

  // Image stream stands at image 1 word 1 on entry.
  task automatic t_unmapped();
    logic [33:0] d;
    rd(4'd0, d);
    check("R10 read ch0 zero", d, 34'd0);
    rd(4'd12, d);
    check("R10 read ch12 zero", d, 34'd0);
    wr(4'd14, 34'd0);
    rd(4'd1, d);
    check("R10 unmapped access moves no stream", d, exp_img(1, 1));
  endtask

  task automatic t_both();
    rd_req = 1'b1;
    rd_chan = 4'd1;
    wr_req = 1'b1;
    wr_chan = 4'd3;
    wr_data = 34'h1_2345_6789;
    @(negedge clk);
    rd_req = 1'b0;
    wr_req = 1'b0;
    check("R11 both acked read", 34'(rd_ack), 34'd1);
    check("R11 both acked write", 34'(wr_ack), 34'd1);
    check("R11 read data", rd_data, exp_img(1, 2));
    check("R11 debug written", dbg_value, 34'h1_2345_6789);
  endtask

  // Input stream stands at word 1 on entry.
  task automatic t_back_to_back();
    rd_req = 1'b1;
    rd_chan = 4'd3;
    @(negedge clk);
    check("R2 held request ack 1", 34'(rd_ack), 34'd1);
    check("R2 held request data 1", rd_data, exp_inp(1));
    @(negedge clk);
    check("R2 held request ack 2", 34'(rd_ack), 34'd1);
    check("R2 held request data 2", rd_data, exp_inp(2));
    rd_req = 1'b0;
    @(negedge clk);
    check("R2 ack drops", 34'(rd_ack), 34'd0);
    check("R2 idle data zero", rd_data, 34'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_image_default();
    t_input_start();
    t_select();
    t_input_wrap();
    t_counter();
    t_debug();
    t_unmapped();
    t_both();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule